// File: doc/BRIEF.md
# Deep Sleep Residency Counter

This block keeps a running measure of the time a processor spends in its deepest idle states. A free-running power-management timer supplies single-cycle tick pulses. Each tick that arrives while the processor-stop input is high adds one to a 24-bit residency count. No other tick changes it. The count never saturates. After all ones it rolls back to zero, and its top bit rolls with it, the same as every other bit. Only the hardware reset brings the count back to zero.

Software sees the count as a 32-bit read-only word. The count sits in the low 24 bits, and the upper byte reads as zero. A read strobe copies the count into a snapshot register, and the read data comes from that register. A read therefore never shows a count that is half updated, even when a tick lands in the same cycle as the read. A separate write path is meant to be used at initialization. It sets one residency-mode configuration bit, which the block drives out to the logic around it. That write never touches the count.

Top module: `deep_sleep_residency`

## Requirements
- R1: While `rstN` is low and after it rises, `rdData` is 0 and `residencyMode` is 0, until the first tick or write.
- R2: Each clock edge where `tmrTick` and `cpuStopped` are both 1 adds exactly one to the count. This holds for ticks in back-to-back cycles too.
- R3: A tick that arrives while `cpuStopped` is 0 leaves the count unchanged.
- R4: While `tmrTick` is 0, the count holds, whatever the value of `cpuStopped`.
- R5: The count is modulo 2^CNT_W. From all ones it goes to zero, and its top bit clears like any other bit.
- R6: At a clock edge where `rdStrobe` is 1, `rdData[CNT_W-1:0]` takes the count as it stood before that edge's increment. `rdData` then holds until the next read strobe.
- R7: Bits `rdData[REG_W-1:CNT_W]` (31:24 by default) always read 0.
- R8: At a clock edge where `cfgWrEn` is 1, `residencyMode` takes `cfgWrData`. Otherwise it holds.
- R9: Neither a configuration write nor a change of `cpuStopped` clears the count. Only a low `rstN` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low, synchronous |
| tmrTick | input | 1 | Power-management timer tick, one cycle per tick |
| cpuStopped | input | 1 | High while the processor is stopped in deep sleep |
| rdStrobe | input | 1 | Read request; captures the count into the read register |
| rdData | output | REG_W (32) | Read word: snapshot of the count in the low CNT_W bits, zero above |
| cfgWrEn | input | 1 | Write enable for the residency-mode bit |
| cfgWrData | input | 1 | Value written to the residency-mode bit |
| residencyMode | output | 1 | Residency-mode configuration bit |

## Verification
A counter that misses a step, takes a double step or counts an unqualified tick shows up in the very next read word. Every later read carries the same offset, so one bad increment cannot hide. A stale or wrongly timed snapshot appears one cycle after the read strobe as a read word that is off by exactly one, or that fails to change. A top bit that sticks, or a count cleared by the wrong event, appears on the first read after the wrap or after that event.

// File: rtl/residency_pkg.sv
package residency_pkg;

  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic incEn;    // qualified timer tick: add one to the count
    logic snapEn;   // capture the count into the read register
    logic modeWr;   // load the residency-mode bit
    logic modeVal;  // value for the residency-mode bit
  } resStrobes_t;

endpackage

// File: rtl/residency_ctrl.sv
module residency_ctrl
  import residency_pkg::*;
(
  input  logic        tmrTick,
  input  logic        cpuStopped,
  input  logic        rdStrobe,
  input  logic        cfgWrEn,
  input  logic        cfgWrData,
  output resStrobes_t strb
);

  always_comb begin
    strb         = '0;
    // a tick counts only while the processor is stopped
    strb.incEn   = tmrTick & cpuStopped;
    strb.snapEn  = rdStrobe;
    strb.modeWr  = cfgWrEn;
    strb.modeVal = cfgWrData;
  end

endmodule

// File: rtl/residency_dp.sv
module residency_dp
  import residency_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  resStrobes_t      strb,
  output logic [REG_W-1:0] rdData,
  output logic             modeQ
);

  localparam int PAD_W = REG_W - CNT_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] snapQ;

  // Residency count: wraps modulo 2^CNT_W, cleared only by hardware reset
  always_ff @(posedge clk) begin
    if (!rstN)           cntQ <= '0;
    else if (strb.incEn) cntQ <= cntQ + ONE;
  end

  // Read snapshot: takes the pre-increment value so a read is coherent
  always_ff @(posedge clk) begin
    if (!rstN)            snapQ <= '0;
    else if (strb.snapEn) snapQ <= cntQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            modeQ <= 1'b0;
    else if (strb.modeWr) modeQ <= strb.modeVal;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdData = {{PAD_W{1'b0}}, snapQ};
    end else begin : g_nopad
      assign rdData = snapQ[REG_W-1:0];
    end
  endgenerate

  // R2 R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.incEn |=> cntQ == $past(cntQ) + ONE);

  // R3 R4 R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.incEn |=> $stable(cntQ));

  // R6
  snap_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.snapEn |=> snapQ == $past(cntQ));

  // R6
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.snapEn |=> $stable(snapQ));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.modeWr |=> $stable(modeQ));

endmodule

// File: rtl/deep_sleep_residency.sv
module deep_sleep_residency
  import residency_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tmrTick,
  input  logic             cpuStopped,
  input  logic             rdStrobe,
  output logic [REG_W-1:0] rdData,
  input  logic             cfgWrEn,
  input  logic             cfgWrData,
  output logic             residencyMode
);

  resStrobes_t strb;

  residency_ctrl u_ctrl (
    .tmrTick   (tmrTick),
    .cpuStopped(cpuStopped),
    .rdStrobe  (rdStrobe),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .strb      (strb)
  );

  residency_dp #(.CNT_W(CNT_W), .REG_W(REG_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .rdData(rdData),
    .modeQ (residencyMode)
  );

endmodule

// File: tb/sim_deep_sleep_residency.sv
`timescale 1ns/1ps
module sim_deep_sleep_residency;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tmrTick = 1'b0, cpuStopped = 1'b0, rdStrobe = 1'b0;
  logic cfgWrEn = 1'b0, cfgWrData = 1'b0;
  logic [31:0] rdData, rdDataW;
  logic residencyMode, modeW;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  deep_sleep_residency u0 (
    .clk(clk), .rstN(rstN), .tmrTick(tmrTick), .cpuStopped(cpuStopped),
    .rdStrobe(rdStrobe), .rdData(rdData), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .residencyMode(residencyMode));

  // narrow instance to reach the wrap point
  deep_sleep_residency #(.CNT_W(6), .REG_W(32)) u1 (
    .clk(clk), .rstN(rstN), .tmrTick(tmrTick), .cpuStopped(cpuStopped),
    .rdStrobe(rdStrobe), .rdData(rdDataW), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .residencyMode(modeW));

  // {tick, stop, rd, expected rdData after the edge}
  localparam int NV = 10;
  localparam logic [26:0] VECS [NV] = '{
    {1'b1, 1'b1, 1'b0, 24'd0},  // R2 count 1, read data unchanged
    {1'b1, 1'b1, 1'b1, 24'd1},  // R6 R2 snapshot before increment
    {1'b0, 1'b1, 1'b1, 24'd2},  // R4
    {1'b1, 1'b0, 1'b1, 24'd2},  // R3 tick ignored
    {1'b0, 1'b0, 1'b1, 24'd2},  // R4
    {1'b1, 1'b1, 1'b0, 24'd2},  // R6 hold
    {1'b1, 1'b1, 1'b1, 24'd3},  // R6
    {1'b0, 1'b1, 1'b1, 24'd4},  // R2
    {1'b1, 1'b0, 1'b0, 24'd4},  // R3
    {1'b0, 1'b0, 1'b1, 24'd4}   // R3 R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic s, input logic r,
                     input logic w = 1'b0, input logic wd = 1'b0);
    tmrTick = t; cpuStopped = s; rdStrobe = r; cfgWrEn = w; cfgWrData = wd;
    @(negedge clk);
    tmrTick = 1'b0; rdStrobe = 1'b0; cfgWrEn = 1'b0; cfgWrData = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    check("R1 rdData", rdData, 32'd0);
    check("R1 mode", {31'd0, residencyMode}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      cyc(VECS[i][26], VECS[i][25], VECS[i][24]);
      check($sformatf("R2/R6 vec%0d", i), rdData, {8'd0, VECS[i][23:0]});
    end

    // R8 R9: mode write does not clear or change count (count is 4)
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R8 mode set", {31'd0, residencyMode}, 32'd1);
    cyc(1'b0, 1'b0, 1'b1);
    check("R9 count kept after write", rdData, 32'd4);
    cyc(1'b0, 1'b0, 1'b0);
    check("R8 mode held", {31'd0, residencyMode}, 32'd1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R8 mode cleared", {31'd0, residencyMode}, 32'd0);

    // R2 long run of spaced ticks
    for (int i = 0; i < 1000; i++) begin
      cyc(1'b1, 1'b1, 1'b0);
      cyc(1'b0, 1'b1, 1'b0);
    end
    cyc(1'b0, 1'b0, 1'b1);
    check("R2 long run", rdData, 32'd1004);

    // R5 wrap on the narrow instance, R7 upper bits zero
    doReset();
    for (int i = 0; i < 63; i++) cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b1);
    check("R5 all ones", rdDataW, 32'd63);
    cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b1);
    check("R5 wrap to zero", rdDataW, 32'd0);
    check("R7 wide no wrap", rdData, 32'd64);
    cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b0, 0, 1'b1);
    check("R5 counts after wrap", rdDataW, 32'd1);

    // R7 wide instance upper byte stays zero
    for (int i = 0; i < 200; i++) cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    check("R7 upper byte zero", {24'd0, rdData[31:24]}, 32'd0);
    check("R2 after wrap test", rdData, 32'd265);

    // R9 only hardware reset clears
    doReset();
    cyc(1'b0, 1'b0, 1'b1);
    check("R9 reset clears", rdData, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule